// File: doc/BRIEF.md
# Multi-byte tuple symbol decoder

This block turns a group of bytes that arrive together in one clock into a single code of an automaton's input alphabet. A downstream state machine can then advance by a whole group of bytes per step. Every possible group yields exactly one output: either the code stored for its class, or a reserved default code with a miss flag set.

The lookup walks a compressed trie, one level per byte of the group. Each level keeps its own node memory. A node holds a 256-bit presence map and a base pointer. If the current byte's bit is clear, the branch does not exist. If the bit is set, the next node sits at the base pointer plus the number of set bits that lie below that byte. A final leaf memory maps the last address to the symbol code. The levels form a pipeline, so one group enters and one code leaves on every clock.

The memories are filled through a plain write port while no data is streaming. The data path carries only a valid qualifier and has no back-pressure. The block accepts a group on any clock where `in_valid` is high and never stalls. The consumer must take each result in the cycle where `out_valid` is high.

Top module: `tuple_sym_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `out_valid` is 0. Node and leaf memory contents are not cleared by reset.
- R2: `out_valid` equals `in_valid` delayed by exactly NBYTES+1 clocks, gaps included.
- R3: Byte k of the group is `in_bytes[8k+7:8k]` and is resolved at trie level k. The walk starts at node address 0 of level 0.
- R4: At a set bit, the next address is the node's base pointer plus the count of set map bits strictly below the byte value, taken modulo 2**AW.
- R5: A clear map bit at any level gives `out_miss`=1 and `out_sym`=DEFAULT_SYM (all ones by default), whatever the later bytes are.
- R6: Groups presented on consecutive clocks are each decoded independently, with no stall.
- R7: `cfg_sel`=k (k < NBYTES) writes node memory of level k, and `cfg_sel`=NBYTES writes leaf memory, at `cfg_addr`. A node word holds the map in bits [255:0] and the base pointer in bits [255+AW:256]. A leaf uses the low SYM_W bits. A write changes only the addressed entry.
- R8: When every level hits, `out_miss`=0 and `out_sym` is the leaf entry at the final address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline valid bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | $clog2(NBYTES+1) | Target memory: level index, or NBYTES for leaves |
| cfg_addr | input | AW | Entry address within the target memory |
| cfg_data | input | 256+AW | Node word, or leaf code in the low bits |
| in_valid | input | 1 | Group present this clock |
| in_bytes | input | 8*NBYTES | Byte group, byte 0 in the low bits |
| out_valid | output | 1 | Result present this clock |
| out_sym | output | SYM_W | Decoded symbol code |
| out_miss | output | 1 | Group has no branch at some level |

## Verification
A wrong popcount, base pointer or byte selection sends the walk to another node, so the port shows a different leaf code or a spurious miss exactly NBYTES+1 clocks after the group enters. Misalignment of the byte delay lines only shows up when different groups are streamed back to back, so the stream test packs distinct groups on consecutive clocks. A broken valid pipeline shows as `out_valid` set one clock early or late, or dropped in a gap. Rewriting one entry and then reading both it and its neighbours shows a write that lands in the wrong memory or address.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  localparam int ALPHA = 256;

  // Number of set bits of the map at positions strictly below pos.
  function automatic logic [8:0] count_below(input logic [ALPHA-1:0] bm, input logic [7:0] pos);
    logic [8:0] n;
    n = '0;
    for (int i = 0; i < ALPHA; i++) begin
      if (i < int'(pos)) n = n + 9'(bm[i]);
    end
    return n;
  endfunction
endpackage

// File: rtl/tsd_level.sv
module tsd_level #(
  parameter int AW = 6,
  localparam int NODE_W = tsd_pkg::ALPHA + AW,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [NODE_W-1:0] wr_data,
  input  logic              up_valid,
  input  logic              up_miss,
  input  logic [AW-1:0]     up_addr,
  input  logic [7:0]        up_byte,
  output logic              dn_valid,
  output logic              dn_miss,
  output logic [AW-1:0]     dn_addr
);
  logic [NODE_W-1:0] mem [DEPTH];
  logic [NODE_W-1:0] node_q;
  logic [7:0]        byte_q;
  logic              miss_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    node_q <= mem[up_addr];
    byte_q <= up_byte;
    miss_q <= up_miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= up_valid;
  end

  logic [tsd_pkg::ALPHA-1:0] bmap;
  logic [AW-1:0]             base;
  logic [8:0]                below;

  always_comb begin
    bmap  = node_q[tsd_pkg::ALPHA-1:0];
    base  = node_q[NODE_W-1:tsd_pkg::ALPHA];
    below = tsd_pkg::count_below(bmap, byte_q);
  end

  assign dn_valid = valid_q;
  assign dn_miss  = miss_q | ~bmap[byte_q];
  assign dn_addr  = base + AW'(below);
endmodule

// File: rtl/tsd_leaf.sv
module tsd_leaf #(
  parameter int AW = 6,
  parameter int SYM_W = 10,
  parameter logic [SYM_W-1:0] DEFAULT_SYM = '1,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [SYM_W-1:0] wr_data,
  input  logic             up_valid,
  input  logic             up_miss,
  input  logic [AW-1:0]    up_addr,
  output logic             dn_valid,
  output logic             dn_miss,
  output logic [SYM_W-1:0] dn_sym
);
  logic [SYM_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    dn_sym  <= up_miss ? DEFAULT_SYM : mem[up_addr];
    dn_miss <= up_miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dn_valid <= 1'b0;
    else        dn_valid <= up_valid;
  end
endmodule

// File: rtl/tuple_sym_decoder.sv
module tuple_sym_decoder #(
  parameter int NBYTES = 4,
  parameter int AW = 6,
  parameter int SYM_W = 10,
  parameter logic [SYM_W-1:0] DEFAULT_SYM = '1,
  localparam int SEL_W = $clog2(NBYTES + 1),
  localparam int NODE_W = tsd_pkg::ALPHA + AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [NODE_W-1:0]   cfg_data,
  input  logic                in_valid,
  input  logic [8*NBYTES-1:0] in_bytes,
  output logic                out_valid,
  output logic [SYM_W-1:0]    out_sym,
  output logic                out_miss
);
  logic          v_w [NBYTES+1];
  logic          m_w [NBYTES+1];
  logic [AW-1:0] a_w [NBYTES+1];

  assign v_w[0] = in_valid;
  assign m_w[0] = 1'b0;
  assign a_w[0] = '0;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lvl
    logic [7:0] lvl_byte;

    if (k == 0) begin : g_direct
      assign lvl_byte = in_bytes[7:0];
    end else begin : g_delay
      // Byte k is consumed k clocks after the group enters.
      logic [7:0] dl [k];
      always_ff @(posedge clk) begin
        dl[0] <= in_bytes[k*8 +: 8];
        for (int j = 1; j < k; j++) dl[j] <= dl[j-1];
      end
      assign lvl_byte = dl[k-1];
    end

    tsd_level #(.AW(AW)) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_sel == SEL_W'(k))),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_data),
      .up_valid (v_w[k]),
      .up_miss  (m_w[k]),
      .up_addr  (a_w[k]),
      .up_byte  (lvl_byte),
      .dn_valid (v_w[k+1]),
      .dn_miss  (m_w[k+1]),
      .dn_addr  (a_w[k+1])
    );
  end

  tsd_leaf #(.AW(AW), .SYM_W(SYM_W), .DEFAULT_SYM(DEFAULT_SYM)) u_leaf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we && (cfg_sel == SEL_W'(NBYTES))),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_data[SYM_W-1:0]),
    .up_valid (v_w[NBYTES]),
    .up_miss  (m_w[NBYTES]),
    .up_addr  (a_w[NBYTES]),
    .dn_valid (out_valid),
    .dn_miss  (out_miss),
    .dn_sym   (out_sym)
  );
endmodule

// File: rtl/tsd_checker.sv
module tsd_checker #(
  parameter int NBYTES = 4,
  parameter int SYM_W = 10,
  parameter logic [SYM_W-1:0] DEFAULT_SYM = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_miss,
  input logic [SYM_W-1:0] out_sym
);
  // Independent record of when groups entered.
  logic [NBYTES:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else        seen <= {seen[NBYTES-1:0], in_valid};
  end

  // R1: nothing leaves while reset is held
  always @(posedge clk) begin
    if (!rst_n) a_r1_quiet_in_reset: assert (!out_valid) else $error("out_valid set in reset");
  end

  // R1: first clock after reset release is quiet
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R2: fixed latency of NBYTES+1 clocks
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == seen[NBYTES]);

  // R5: a miss always carries the default code
  a_r5_miss_default: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_sym == DEFAULT_SYM));
endmodule

bind tuple_sym_decoder tsd_checker #(
  .NBYTES(NBYTES), .SYM_W(SYM_W), .DEFAULT_SYM(DEFAULT_SYM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_miss(out_miss), .out_sym(out_sym)
);

// File: tb/tuple_sym_decoder_test.sv
module tuple_sym_decoder_test;
  localparam int N = 4;
  localparam int AW = 6;
  localparam int SW = 10;
  localparam int DW = 256 + AW;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;
  logic in_valid = 1'b0;
  logic [8*N-1:0] in_bytes = '0;
  logic out_valid;
  logic [SW-1:0] out_sym;
  logic out_miss;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tuple_sym_decoder #(.NBYTES(N), .AW(AW), .SYM_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
    .in_bytes(in_bytes), .out_valid(out_valid), .out_sym(out_sym),
    .out_miss(out_miss)
  );

  // {group (byte 0 low), expected code, expected miss}
  localparam logic [42:0] VEC [NV] = '{
    {32'h01_20_10_00, 10'h011, 1'b0},
    {32'h02_30_41_41, 10'h066, 1'b0},
    {32'h40_31_41_41, 10'h099, 1'b0},
    {32'h03_30_41_41, 10'h077, 1'b0},
    {32'hAA_01_80_41, 10'h0BB, 1'b0},
    {32'h05_3A_80_41, 10'h140, 1'b0},  // level-2 address wraps 66 -> 2
    {32'hFF_00_02_42, 10'h1F1, 1'b0},
    {32'hFE_00_02_42, 10'h1E0, 1'b0},
    {32'h80_FF_FF_FF, 10'h3F0, 1'b0},
    {32'h00_00_00_43, 10'h3FF, 1'b1},  // miss at level 0
    {32'h01_20_11_00, 10'h3FF, 1'b1},  // miss at level 1
    {32'h02_32_41_41, 10'h3FF, 1'b1},  // miss at level 2
    {32'h04_30_41_41, 10'h3FF, 1'b1},  // miss at level 3
    {32'h05_3A_81_41, 10'h3FF, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] b(input int k);
    return 256'b1 << k;
  endfunction

  function automatic logic [DW-1:0] nd(input logic [AW-1:0] base, input logic [255:0] bm);
    return {base, bm};
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] addr, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_one(input logic [31:0] grp, input logic [SW-1:0] esym, input logic emiss, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_bytes = grp;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (N - 1) @(negedge clk);
    chk("R2", "early valid", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R2", "valid", 32'(out_valid), 32'd1);
    chk(req, "sym", 32'(out_sym), 32'(esym));
    chk("R5 R8", "miss", 32'(out_miss), 32'(emiss));
    @(negedge clk);
    chk("R2", "valid drop", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", 32'(out_valid), 32'd0);

    // R7: program the trie
    wr(0, 0, nd(2, b(8'h00) | b(8'h41) | b(8'h42) | b(8'hFF)));
    wr(1, 2, nd(0, b(8'h10)));
    wr(1, 3, nd(1, b(8'h41) | b(8'h80)));
    wr(1, 4, nd(10, 256'hFF));
    wr(1, 5, nd(63, b(8'hFF)));
    wr(2, 0, nd(0, b(8'h20)));
    wr(2, 1, nd(4, b(8'h30) | b(8'h31)));
    wr(2, 2, nd(8, '1));
    wr(2, 12, nd(20, b(8'h00)));
    wr(2, 63, nd(62, b(8'hFF)));
    wr(3, 0, nd(0, b(8'h01)));
    wr(3, 4, nd(6, b(8'h02) | b(8'h03)));
    wr(3, 5, nd(9, b(8'h40)));
    wr(3, 9, nd(11, b(8'hAA)));
    wr(3, 2, nd(40, b(8'h05)));
    wr(3, 20, nd(30, b(8'hFE) | b(8'hFF)));
    wr(3, 62, nd(63, b(8'h80)));
    wr(4, 0, DW'(10'h011));
    wr(4, 6, DW'(10'h066));
    wr(4, 7, DW'(10'h077));
    wr(4, 9, DW'(10'h099));
    wr(4, 11, DW'(10'h0BB));
    wr(4, 30, DW'(10'h1E0));
    wr(4, 31, DW'(10'h1F1));
    wr(4, 63, DW'(10'h3F0));
    wr(4, 40, DW'(10'h140));
    repeat (N + 2) @(negedge clk);

    // R6: back-to-back stream of every vector
    for (int j = 0; j < NV + N + 2; j++) begin
      @(negedge clk);
      if (j >= N + 1 && j - N - 1 < NV) begin
        chk("R2 R6", "stream valid", 32'(out_valid), 32'd1);
        chk("R3 R4 R8", "stream sym", 32'(out_sym), 32'(VEC[j-N-1][10:1]));
        chk("R5", "stream miss", 32'(out_miss), 32'(VEC[j-N-1][0]));
      end else begin
        chk("R2", "stream idle", 32'(out_valid), 32'd0);
      end
      if (j < NV) begin
        in_valid = 1'b1; in_bytes = VEC[j][42:11];
      end else begin
        in_valid = 1'b0;
      end
    end

    // R2: one-clock gap between two groups
    for (int j = 0; j < N + 5; j++) begin
      @(negedge clk);
      if (j == N + 1) begin
        chk("R2", "gap first", 32'(out_valid), 32'd1);
        chk("R8", "gap first sym", 32'(out_sym), 32'h011);
      end else if (j == N + 3) begin
        chk("R2", "gap second", 32'(out_valid), 32'd1);
        chk("R8", "gap second sym", 32'(out_sym), 32'h099);
      end else begin
        chk("R2", "gap idle", 32'(out_valid), 32'd0);
      end
      in_valid = (j == 0) || (j == 2);
      in_bytes = (j == 0) ? VEC[0][42:11] : VEC[2][42:11];
    end

    // R5: miss at the last level, later bytes irrelevant
    run_one(32'h04_30_41_41, 10'h3FF, 1'b1, "R5");
    // R4: wrap modulo 2**AW at level 2
    run_one(32'h05_3A_80_41, 10'h140, 1'b0, "R4");

    // R1: reset in the middle of a lookup drops it, memories survive
    @(negedge clk);
    in_valid = 1'b1; in_bytes = VEC[1][42:11];
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "valid in mid reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    for (int j = 0; j < N + 2; j++) begin
      @(negedge clk);
      chk("R1", "flushed lookup", 32'(out_valid), 32'd0);
    end
    run_one(32'h02_30_41_41, 10'h066, 1'b0, "R1");

    // R7: extend one node and add a leaf; neighbours unchanged
    wr(3, 4, nd(6, b(8'h02) | b(8'h03) | b(8'h04)));
    wr(4, 8, DW'(10'h088));
    run_one(32'h04_30_41_41, 10'h088, 1'b0, "R7");
    run_one(32'h02_30_41_41, 10'h066, 1'b0, "R7");
    run_one(32'h03_30_41_41, 10'h077, 1'b0, "R7");
    run_one(32'h40_31_41_41, 10'h099, 1'b0, "R7");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule